// File: doc/BRIEF.md
# Multi-Mode Transmit Line Serializer

This block converts parallel transmit data from the overhead-processing stage into line-rate output for an optical-line transmitter. It works in two ways. In the quad low-rate modes, each of four lanes takes one byte per word period and shifts it out one bit per line clock. In the high-rate mode, one 32-bit word is taken per word period and sent as two 16-bit halves on consecutive line clocks to an external multiplexer.

The whole block runs in the single transmit line clock domain. Every register acts on the rising edge. A load strobe tells upstream logic in which cycle the next word must be on the inputs. The word is captured at the clock edge that ends that cycle. A separate clock-enable output marks the internal-rate period, which is one line cycle in eight or one in two, chosen by a divide select.

In the quad modes, a facility loopback enable replaces each serial output with the matching receive-side bit. An optional frame-sync input realigns the word boundary. It is synchronous to the line clock and lasts one line cycle or longer.

Top module: `tx_line_serdes`

## Requirements
- R1: While `rst` is high, and after it is released until the first word load edge, `ser_out` and `half_out` are all zero. `load_stb` is 1 in the first cycle after release.
- R2: In quad mode (`mode_hi`=0), `load_stb` is high in exactly one cycle of every 8, and the word is captured at the edge that ends that cycle.
- R3: In quad mode, lane i serializes `lane_data[8i+7:8i]` most significant bit first. Bit 7 appears in the cycle after the load edge and bit 0 appears seven cycles later.
- R4: In wide mode (`mode_hi`=1), `load_stb` is high in one cycle of every 2. The captured word shows bits [31:16] on `half_out` in the cycle after the load edge, then bits [15:0] in the next cycle.
- R5: In quad mode with `loop_en`=1 and after the first load, `ser_out[i]` equals `rx_loop[i]` in the same cycle.
- R6: In wide mode, `loop_en` has no effect: `half_out` carries transmit data and `ser_out` is zero. In quad mode, `half_out` is zero.
- R7: `int_ce` pulses once every 8 cycles when `div_sel`=1 and once every 2 cycles when `div_sel`=0. After reset, the first pulse is in cycle 7 (or cycle 1), counting the release cycle as 0.
- R8: A rising edge of `fsync` seen at clock edge E suppresses any load at E and raises `load_stb` in the cycle after E. The next word is therefore loaded at E+1. The `int_ce` divider restarts at E, so its next pulse is in the cycle that is ratio-1 cycles after the one following E.
- R9: An `fsync` pulse held high for several cycles realigns only once, on its rising edge. The stream then proceeds with a normal word period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit line clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_hi | input | 1 | 0 = quad byte serialization, 1 = 32-to-16 gearbox |
| div_sel | input | 1 | 1 = internal enable every 8 cycles, 0 = every 2 |
| loop_en | input | 1 | Facility loopback enable (quad mode only) |
| fsync | input | 1 | Optional frame-sync, synchronous to clk |
| lane_data | input | 32 | Four lane bytes, lane i in bits [8i+7:8i] |
| wide_data | input | 32 | High-rate transmit word |
| rx_loop | input | 4 | Receive-side loopback bits, one per lane |
| ser_out | output | 4 | Serial line outputs, one per lane |
| half_out | output | 16 | 16-bit gearbox output |
| load_stb | output | 1 | Present the next word in this cycle |
| int_ce | output | 1 | Internal-rate clock enable |

## Verification
The bench targets bit order and word-boundary timing. A reversed shift or an off-by-one load edge shows up as swapped or shifted bits on every lane. It holds `fsync` high for several cycles after its rising edge. A design that realigns on level instead of edge keeps suppressing loads and stalls the stream. It also checks that the divider restarts on that edge. Loopback is enabled in both modes: a design that ignores the mode either fails to echo `rx_loop` in quad mode or corrupts `half_out` in wide mode. Both divide ratios are checked from reset, so a miscounted wrap gives a wrong pulse spacing.

// File: rtl/tx_line_pkg.sv
package tx_line_pkg;

  // Last phase index of a word period for the active mode.
  function automatic int unsigned last_phase(input logic wide_mode, input int unsigned byte_w);
    return wide_mode ? 1 : byte_w - 1;
  endfunction

  // Number of line cycles per internal-rate period.
  function automatic int unsigned div_ratio(input logic slow_sel, input int unsigned slow_div,
                                            input int unsigned fast_div);
    return slow_sel ? slow_div : fast_div;
  endfunction

  // Bit of lane byte visible k cycles after the load edge (MSB first).
  function automatic int unsigned ser_bit_index(input int unsigned k, input int unsigned byte_w);
    return byte_w - 1 - k;
  endfunction

endpackage

// File: rtl/tx_phase_ctl.sv
module tx_phase_ctl #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned PH_W = $clog2(BYTE_W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_hi,
  input  logic            fsync,
  output logic [PH_W-1:0] ph,
  output logic            load_stb,
  output logic            fs_rise,
  output logic            primed
);
  import tx_line_pkg::*;

  localparam logic [PH_W-1:0] PH_MAX = PH_W'(BYTE_W - 1);

  logic            fs_q;
  logic [PH_W-1:0] last;
  logic            at_end;

  assign last     = PH_W'(last_phase(mode_hi, BYTE_W));
  assign at_end   = (ph >= last);
  assign fs_rise  = fsync & ~fs_q;
  assign load_stb = at_end & ~fs_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_MAX;
      fs_q   <= 1'b0;
      primed <= 1'b0;
    end else begin
      fs_q <= fsync;
      if (fs_rise) begin
        ph <= PH_MAX;
      end else if (at_end) begin
        ph     <= '0;
        primed <= 1'b1;
      end else begin
        ph <= ph + PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/tx_lane_ser.sv
module tx_lane_ser #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic              dout
);
  logic [BYTE_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst)       shreg <= '0;
    else if (load) shreg <= din;
    else           shreg <= {shreg[BYTE_W-2:0], 1'b0};
  end

  assign dout = shreg[BYTE_W-1];
endmodule

// File: rtl/tx_word_gearbox.sv
module tx_word_gearbox #(
  parameter int unsigned WIDE_W = 32,
  parameter int unsigned PH_W   = 3,
  localparam int unsigned HALF_W = WIDE_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PH_W-1:0]   ph,
  input  logic [WIDE_W-1:0] din,
  output logic [HALF_W-1:0] dout
);
  logic [WIDE_W-1:0] hold;
  logic              sel_low;

  always_ff @(posedge clk) begin
    if (rst)       hold <= '0;
    else if (load) hold <= din;
  end

  assign sel_low = (ph == PH_W'(1));
  assign dout    = sel_low ? hold[HALF_W-1:0] : hold[WIDE_W-1:HALF_W];
endmodule

// File: rtl/tx_clk_div.sv
module tx_clk_div #(
  parameter int unsigned SLOW_DIV = 8,
  parameter int unsigned FAST_DIV = 2,
  localparam int unsigned CW = $clog2(SLOW_DIV)
) (
  input  logic clk,
  input  logic rst,
  input  logic div_sel,
  input  logic restart,
  output logic int_ce
);
  import tx_line_pkg::*;

  logic [CW-1:0] cnt;
  logic [CW-1:0] top_val;

  assign top_val = CW'(div_ratio(div_sel, SLOW_DIV, FAST_DIV) - 1);
  assign int_ce  = (cnt >= top_val);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (int_ce)    cnt <= '0;
    else                cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/tx_line_serdes.sv
module tx_line_serdes #(
  parameter int unsigned LANES    = 4,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned WIDE_W   = 32,
  parameter int unsigned SLOW_DIV = 8,
  parameter int unsigned FAST_DIV = 2,
  localparam int unsigned HALF_W  = WIDE_W / 2,
  localparam int unsigned PH_W    = $clog2(BYTE_W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mode_hi,
  input  logic                    div_sel,
  input  logic                    loop_en,
  input  logic                    fsync,
  input  logic [LANES*BYTE_W-1:0] lane_data,
  input  logic [WIDE_W-1:0]       wide_data,
  input  logic [LANES-1:0]        rx_loop,
  output logic [LANES-1:0]        ser_out,
  output logic [HALF_W-1:0]       half_out,
  output logic                    load_stb,
  output logic                    int_ce
);
  logic [PH_W-1:0]   ph;
  logic              fs_rise;
  logic              primed;
  logic [LANES-1:0]  lane_bits;
  logic [HALF_W-1:0] gear_word;

  tx_phase_ctl #(.BYTE_W(BYTE_W)) u_phase (
    .clk(clk), .rst(rst), .mode_hi(mode_hi), .fsync(fsync),
    .ph(ph), .load_stb(load_stb), .fs_rise(fs_rise), .primed(primed)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    tx_lane_ser #(.BYTE_W(BYTE_W)) u_ser (
      .clk(clk), .rst(rst), .load(load_stb),
      .din(lane_data[i*BYTE_W +: BYTE_W]), .dout(lane_bits[i])
    );
  end

  tx_word_gearbox #(.WIDE_W(WIDE_W), .PH_W(PH_W)) u_gear (
    .clk(clk), .rst(rst), .load(load_stb), .ph(ph),
    .din(wide_data), .dout(gear_word)
  );

  tx_clk_div #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_div (
    .clk(clk), .rst(rst), .div_sel(div_sel), .restart(fs_rise), .int_ce(int_ce)
  );

  always_comb begin
    ser_out  = '0;
    half_out = '0;
    if (primed) begin
      if (mode_hi) half_out = gear_word;
      else         ser_out  = loop_en ? rx_loop : lane_bits;
    end
  end
endmodule

// File: rtl/tx_line_serdes_chk.sv
module tx_line_serdes_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned WIDE_W = 32,
  localparam int unsigned HALF_W = WIDE_W / 2
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_hi,
  input logic              loop_en,
  input logic [WIDE_W-1:0] wide_data,
  input logic [LANES-1:0]  rx_loop,
  input logic [LANES-1:0]  ser_out,
  input logic [HALF_W-1:0] half_out,
  input logic              load_stb,
  input logic              int_ce,
  input logic              primed,
  input logic              fs_rise
);
  // R1
  quiet_before_load_chk: assert property (@(posedge clk) disable iff (rst)
    !primed |-> (ser_out == '0 && half_out == '0));

  // R2
  quad_single_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_hi && load_stb) |=> !load_stb);

  // R4
  upper_half_first_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_hi && load_stb) |=> (!mode_hi || half_out == $past(wide_data[WIDE_W-1:HALF_W])));

  // R5
  loop_echo_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && !mode_hi && loop_en) |-> ser_out == rx_loop);

  // R6
  wide_ser_idle_chk: assert property (@(posedge clk) disable iff (rst)
    mode_hi |-> ser_out == '0);

  // R6
  quad_half_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_hi |-> half_out == '0);

  // R7
  ce_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    int_ce |=> !int_ce);

  // R8
  sync_reload_chk: assert property (@(posedge clk) disable iff (rst)
    fs_rise |=> load_stb);
endmodule

bind tx_line_serdes tx_line_serdes_chk #(.LANES(LANES), .WIDE_W(WIDE_W)) u_chk (
  .clk(clk), .rst(rst), .mode_hi(mode_hi), .loop_en(loop_en), .wide_data(wide_data),
  .rx_loop(rx_loop), .ser_out(ser_out), .half_out(half_out), .load_stb(load_stb),
  .int_ce(int_ce), .primed(primed), .fs_rise(fs_rise)
);

// File: tb/sim_tx_line_serdes.sv
`timescale 1ns/1ps
module sim_tx_line_serdes;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_hi = 1'b0, div_sel = 1'b1, loop_en = 1'b0, fsync = 1'b0;
  logic [31:0] lane_data = '0, wide_data = '0;
  logic [3:0]  rx_loop = '0;
  logic [3:0]  ser_out;
  logic [15:0] half_out;
  logic        load_stb, int_ce;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tx_line_serdes u0 (
    .clk(clk), .rst(rst), .mode_hi(mode_hi), .div_sel(div_sel), .loop_en(loop_en),
    .fsync(fsync), .lane_data(lane_data), .wide_data(wide_data), .rx_loop(rx_loop),
    .ser_out(ser_out), .half_out(half_out), .load_stb(load_stb), .int_ce(int_ce)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] lane_bits(input logic [31:0] d, input int k);
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = d[8*i + 7 - k];
    return v;
  endfunction

  // Leaves the bench in the release cycle (before the first post-reset edge).
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    fsync = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk("R1 ser_out in reset", {28'd0, ser_out}, 32'd0);
    chk("R1 half_out in reset", {16'd0, half_out}, 32'd0);
    rst = 1'b0;
    #1;
    chk("R1 load_stb after release", {31'd0, load_stb}, 32'd1);
    chk("R1 ser_out after release", {28'd0, ser_out}, 32'd0);
  endtask

  task automatic t_quad_stream();
    logic [31:0] pats [3] = '{32'hA53CF081, 32'h00FF5AC3, 32'h9612E77E};
    mode_hi = 1'b0; loop_en = 1'b0;
    do_reset();
    for (int b = 0; b < 3; b++) begin
      lane_data = pats[b];
      for (int k = 0; k < 8; k++) begin
        @(negedge clk); #1;
        chk("R3 lane bits MSB first", {28'd0, ser_out}, {28'd0, lane_bits(pats[b], k)});
        chk("R2 load strobe period 8", {31'd0, load_stb}, {31'd0, k == 7});
        chk("R6 half_out idle in quad", {16'd0, half_out}, 32'd0);
      end
    end
  endtask

  task automatic t_wide_stream(input logic lp);
    logic [31:0] pats [3] = '{32'hDEAD1234, 32'h0F0FF0F0, 32'h8001_7FFE};
    mode_hi = 1'b1; loop_en = lp; rx_loop = 4'hF;
    do_reset();
    for (int w = 0; w < 3; w++) begin
      wide_data = pats[w];
      for (int k = 0; k < 2; k++) begin
        @(negedge clk); #1;
        chk("R4 half order", {16'd0, half_out},
            {16'd0, (k == 0) ? pats[w][31:16] : pats[w][15:0]});
        chk("R4 load strobe period 2", {31'd0, load_stb}, {31'd0, k == 1});
        chk("R6 ser_out idle in wide", {28'd0, ser_out}, 32'd0);
      end
    end
    loop_en = 1'b0;
  endtask

  task automatic t_loopback();
    mode_hi = 1'b0; loop_en = 1'b1; lane_data = 32'hFFFFFFFF;
    do_reset();
    @(negedge clk);
    for (int j = 0; j < 10; j++) begin
      rx_loop = 4'((j * 5 + 3) & 15);
      #1;
      chk("R5 loopback echo", {28'd0, ser_out}, {28'd0, rx_loop});
      @(negedge clk);
    end
    loop_en = 1'b0;
  endtask

  task automatic t_divider(input logic sel);
    int r;
    r = sel ? 8 : 2;
    div_sel = sel; mode_hi = 1'b0;
    do_reset();
    for (int idx = 0; idx < 24; idx++) begin
      if (idx > 0) begin @(negedge clk); #1; end
      chk("R7 int_ce spacing", {31'd0, int_ce}, {31'd0, (idx % r) == r - 1});
    end
  endtask

  task automatic t_fsync();
    logic [31:0] d;
    d = 32'h5AC3_18E7;
    mode_hi = 1'b0; div_sel = 1'b1; loop_en = 1'b0; lane_data = 32'h11111111;
    do_reset();
    for (int k = 0; k < 3; k++) @(negedge clk);
    fsync = 1'b1;
    #1;
    chk("R8 load suppressed on sync edge", {31'd0, load_stb}, 32'd0);
    @(negedge clk); #1;
    chk("R8 load strobe after sync", {31'd0, load_stb}, 32'd1);
    lane_data = d;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k == 2) fsync = 1'b0;
      #1;
      chk("R9 realigned stream bits", {28'd0, ser_out}, {28'd0, lane_bits(d, k)});
      chk("R9 single realignment strobe", {31'd0, load_stb}, {31'd0, k == 7});
      chk("R8 divider restart", {31'd0, int_ce}, {31'd0, k == 6});
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_quad_stream();
    t_wide_stream(1'b0);
    t_wide_stream(1'b1);
    t_loopback();
    t_divider(1'b1);
    t_divider(1'b0);
    t_fsync();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule